// File: doc/BRIEF.md
# Sound Generator Register Write Port

This block is the byte-wide register front end of a four-channel programmable sound generator, with three square-wave tone channels and one noise channel. A host writes single bytes. A byte with bit 7 set picks one of eight internal registers and loads that register's low bits. A byte with bit 7 clear goes to whichever register was picked last and supplies the upper bits of a tone period. The block holds:

- three 10-bit tone periods;
- four 4-bit attenuations;
- a 3-bit noise control field.

From these it produces the effective tone periods that the tone counters use. It also issues two one-cycle pulses: one tells the noise generator to restart, and one tells the noise rate logic to re-read the channel-2 period.

A ready flag drops on every write. It rises again after a set number of divided-clock ticks, so the host can pace its writes. An elaboration-time variant parameter selects one of three behaviours:

- **standard**: a zero period stands for 1024, and the pointer resets to register 0.
- **zero-literal**: zero stays zero, and the pointer resets to register 3.
- **strict**: some data bytes are dropped, and the noise restart fires only when the mode bit changes.

Tone counting, noise generation and mixing sit outside this block.

Top module: `psg_reg_port`

## Requirements
- R1: A byte with bit 7 = 1 selects register index bits 6:4, writes bits 3:0 into that register's low four bits, and remembers the index as the current pointer.
- R2: A byte with bit 7 = 0 aimed at a tone period register (index 0, 2 or 4 for channels 0, 1, 2) writes byte bits 5:0 into period bits 9:4 and keeps period bits 3:0.
- R3: Index 1, 3, 5 and 7 hold the attenuations of channels 0, 1, 2 and 3 (channel = index >> 1). Either byte type aimed at one of them loads byte bits 3:0 as the new attenuation.
- R4: The effective period output is 11 bits per channel. A stored period of 0 reads as 0x400 in the standard and strict variants and as 0 in the zero-literal variant. Any nonzero stored period passes through unchanged.
- R5: After reset:
  - all periods, attenuations and the noise control field are 0;
  - ready is 1;
  - the pointer is 0, or 3 in the zero-literal variant.
- R6: Index 6 holds the noise control field (bits 1:0 rate, bit 2 mode).
  - In the standard and zero-literal variants, every accepted write to index 6 pulses the noise restart output.
  - In the strict variant, the pulse fires only on a latch byte that changes the mode bit.
- R7: In the strict variant, a byte with bit 7 = 0 aimed at index 1, 3, 5, 6 or 7 changes no register and produces no pulse.
- R8: Ready goes to 0 in the cycle after any write strobe, dropped bytes included. It returns to 1 after the set number of tick-enable cycles that carry no write. A write arriving while ready is 0, or in the same cycle as a tick, re-arms the wait.
- R9: An accepted write to index 4, with either byte type, while the stored noise rate bits 1:0 equal 3 pulses the noise follow output.
- R10: Register and effective-period changes appear in the cycle after the strobe. Restart and follow pulses last exactly one cycle when no further write follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 8 | Written byte |
| tick_en | input | 1 | Divided chip clock enable |
| ready | output | 1 | High when the port can take the next byte |
| tone_period | output | 33 | Effective periods, 11 bits per channel, channel 0 lowest |
| atten | output | 16 | Attenuations, 4 bits per channel, channel 0 lowest |
| noise_ctl | output | 3 | Noise control field: bit 2 mode, bits 1:0 rate |
| noise_restart | output | 1 | One-cycle pulse restarting the noise generator |
| noise_follow | output | 1 | One-cycle pulse asking noise to re-read the channel-2 period |

## Verification
The assertions assume the following about the inputs:
- `wr_en` is a clean single-cycle strobe with `wr_data` stable in the strobe cycle.
- `tick_en` may coincide with a write.

The pulse assertions relate each pulse to a write in the previous cycle. The stimulus drives every input on the falling edge and holds the strobe for one cycle only. It deliberately includes a write that shares a cycle with a tick, and a second write issued while ready is still low. One shared byte stream feeds all three variants at once, so each variant's divergent handling of the same byte is compared directly.

// File: rtl/psg_reg_pkg.sv
package psg_reg_pkg;

  typedef enum logic [1:0] {
    VAR_STD      = 2'd0,
    VAR_ZERO_LIT = 2'd1,
    VAR_STRICT   = 2'd2
  } psg_variant_e;

  localparam int NUM_TONE = 3;
  localparam int NUM_CHAN = 4;
  localparam int PER_W    = 10;
  localparam int LO_W     = 4;
  localparam int PAY_W    = PER_W - LO_W;
  localparam int ATT_W    = 4;
  localparam int CTL_W    = 3;
  localparam int IDX_W    = 3;
  localparam int EFF_W    = PER_W + 1;

  localparam logic [IDX_W-1:0] NOISE_IDX  = IDX_W'(2 * NUM_TONE);
  localparam logic [IDX_W-1:0] FOLLOW_IDX = IDX_W'(2 * (NUM_TONE - 1));

  typedef struct packed {
    logic             strobe;
    logic             is_latch;
    logic [IDX_W-1:0] idx;
    logic             accept;
  } wr_dec_t;

endpackage

// File: rtl/psg_wr_decode.sv
module psg_wr_decode
  import psg_reg_pkg::*;
#(
  parameter psg_variant_e VARIANT = VAR_STD
) (
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] last_idx,
  output wr_dec_t          dec
);

  logic drop;

  always_comb begin
    dec.strobe   = wr_en;
    dec.is_latch = wr_data[7];
    dec.idx      = wr_data[7] ? wr_data[6:4] : last_idx;
    // strict variant discards data bytes aimed at odd registers or noise control
    drop         = (VARIANT == VAR_STRICT) && !wr_data[7] &&
                   (dec.idx[0] || (dec.idx == NOISE_IDX));
    dec.accept   = wr_en && !drop;
  end

endmodule

// File: rtl/psg_reg_bank.sv
module psg_reg_bank
  import psg_reg_pkg::*;
#(
  parameter psg_variant_e VARIANT = VAR_STD
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  wr_dec_t                   dec,
  input  logic [PAY_W-1:0]          payload,
  output logic [NUM_TONE*PER_W-1:0] per_o,
  output logic [NUM_CHAN*ATT_W-1:0] att_o,
  output logic [CTL_W-1:0]          ctl_o,
  output logic [IDX_W-1:0]          last_o,
  output logic                      restart_o,
  output logic                      follow_o
);

  localparam logic [IDX_W-1:0] RST_IDX = (VARIANT == VAR_ZERO_LIT) ? IDX_W'(3) : IDX_W'(0);

  logic [NUM_TONE-1:0][PER_W-1:0] per_q, per_d;
  logic [NUM_CHAN-1:0][ATT_W-1:0] att_q, att_d;
  logic [CTL_W-1:0]               ctl_q, ctl_d;
  logic [IDX_W-1:0]               last_q, last_d;
  logic                           restart_q, restart_d;
  logic                           follow_q, follow_d;

  always_comb begin
    per_d     = per_q;
    att_d     = att_q;
    ctl_d     = ctl_q;
    last_d    = last_q;
    restart_d = 1'b0;
    follow_d  = 1'b0;
    if (dec.strobe && dec.is_latch) last_d = dec.idx;
    if (dec.accept) begin
      for (int i = 0; i < NUM_TONE; i++) begin
        if (dec.idx == IDX_W'(2 * i)) begin
          if (dec.is_latch) per_d[i][LO_W-1:0]     = payload[LO_W-1:0];
          else              per_d[i][PER_W-1:LO_W] = payload;
        end
      end
      for (int i = 0; i < NUM_CHAN; i++) begin
        if (dec.idx == IDX_W'(2 * i + 1)) att_d[i] = payload[ATT_W-1:0];
      end
      if (dec.idx == NOISE_IDX) begin
        ctl_d = payload[CTL_W-1:0];
        if (VARIANT == VAR_STRICT)
          restart_d = dec.is_latch && (payload[2] != ctl_q[2]);
        else
          restart_d = 1'b1;
      end
      if ((dec.idx == FOLLOW_IDX) && (ctl_q[1:0] == 2'b11)) follow_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q     <= '0;
      att_q     <= '0;
      ctl_q     <= '0;
      last_q    <= RST_IDX;
      restart_q <= 1'b0;
      follow_q  <= 1'b0;
    end else begin
      per_q     <= per_d;
      att_q     <= att_d;
      ctl_q     <= ctl_d;
      last_q    <= last_d;
      restart_q <= restart_d;
      follow_q  <= follow_d;
    end
  end

  assign per_o     = per_q;
  assign att_o     = att_q;
  assign ctl_o     = ctl_q;
  assign last_o    = last_q;
  assign restart_o = restart_q;
  assign follow_o  = follow_q;

  // R7: dropped data bytes leave attenuation and noise control untouched
  a_r7_drop_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (VARIANT == VAR_STRICT && dec.strobe && !dec.is_latch &&
     (dec.idx[0] || dec.idx == NOISE_IDX)) |=> ($stable(att_q) && $stable(ctl_q)));

  // R6: strict restart only accompanies a change of the mode bit
  a_r6_strict_mode_change: assert property (@(posedge clk) disable iff (!rst_n)
    (VARIANT == VAR_STRICT && restart_q) |-> (ctl_q[2] != $past(ctl_q[2])));

  // R10: pulses only follow a strobe
  a_r10_restart_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    restart_q |-> $past(dec.strobe));

  // R9: follow pulse only after a write that targeted the channel-2 period
  a_r9_follow_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    follow_q |-> ($past(dec.strobe) && $past(dec.idx) == FOLLOW_IDX));

endmodule

// File: rtl/psg_period_map.sv
module psg_period_map
  import psg_reg_pkg::*;
#(
  parameter psg_variant_e VARIANT = VAR_STD
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_TONE*PER_W-1:0] raw_i,
  output logic [NUM_TONE*EFF_W-1:0] eff_o
);

  localparam logic [EFF_W-1:0] ZERO_SUB = (VARIANT == VAR_ZERO_LIT) ? '0 : EFF_W'(1 << PER_W);

  for (genvar g = 0; g < NUM_TONE; g++) begin : g_ch
    logic [PER_W-1:0] raw;
    assign raw = raw_i[g*PER_W +: PER_W];
    assign eff_o[g*EFF_W +: EFF_W] = (raw == '0) ? ZERO_SUB : {1'b0, raw};

    // R4: outside the zero-literal variant the effective period is never zero
    a_r4_no_zero_period: assert property (@(posedge clk) disable iff (!rst_n)
      (VARIANT != VAR_ZERO_LIT) |-> (eff_o[g*EFF_W +: EFF_W] != '0));
  end

endmodule

// File: rtl/psg_ready_timer.sv
module psg_ready_timer #(
  parameter int READY_TICKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic tick_en,
  output logic ready
);

  localparam int CNT_W = (READY_TICKS < 1) ? 1 : $clog2(READY_TICKS + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_en)                       cnt_d = CNT_W'(READY_TICKS);
    else if (tick_en && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ready = (cnt_q == '0);

  // R8: a strobe always drops ready on the next cycle
  a_r8_low_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !ready);

  // R8: ready only rises on a tick without a write
  a_r8_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(tick_en) && !$past(wr_en)));

endmodule

// File: rtl/psg_reg_port.sv
module psg_reg_port
  import psg_reg_pkg::*;
#(
  parameter psg_variant_e VARIANT     = VAR_STD,
  parameter int           READY_TICKS = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        tick_en,
  output logic        ready,
  output logic [32:0] tone_period,
  output logic [15:0] atten,
  output logic [2:0]  noise_ctl,
  output logic        noise_restart,
  output logic        noise_follow
);

  wr_dec_t                   dec;
  logic [IDX_W-1:0]          last_idx;
  logic [NUM_TONE*PER_W-1:0] per_raw;

  psg_wr_decode #(.VARIANT(VARIANT)) u_dec (
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .last_idx (last_idx),
    .dec      (dec)
  );

  psg_reg_bank #(.VARIANT(VARIANT)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec       (dec),
    .payload   (wr_data[PAY_W-1:0]),
    .per_o     (per_raw),
    .att_o     (atten),
    .ctl_o     (noise_ctl),
    .last_o    (last_idx),
    .restart_o (noise_restart),
    .follow_o  (noise_follow)
  );

  psg_period_map #(.VARIANT(VARIANT)) u_map (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_i (per_raw),
    .eff_o (tone_period)
  );

  psg_ready_timer #(.READY_TICKS(READY_TICKS)) u_rdy (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .tick_en (tick_en),
    .ready   (ready)
  );

endmodule

// File: tb/tb_psg_reg_port.sv
`timescale 1ns/1ps
module tb_psg_reg_port;
  import psg_reg_pkg::*;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, tick_en;
  logic [7:0] wr_data;

  logic        rdy   [3];
  logic [32:0] tp    [3];
  logic [15:0] at    [3];
  logic [2:0]  nc    [3];
  logic        rs    [3];
  logic        fo    [3];

  always #2 clk = ~clk;

  psg_reg_port #(.VARIANT(VAR_STD)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .tick_en(tick_en),
    .ready(rdy[0]), .tone_period(tp[0]), .atten(at[0]), .noise_ctl(nc[0]),
    .noise_restart(rs[0]), .noise_follow(fo[0]));
  psg_reg_port #(.VARIANT(VAR_ZERO_LIT)) dut_zl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .tick_en(tick_en),
    .ready(rdy[1]), .tone_period(tp[1]), .atten(at[1]), .noise_ctl(nc[1]),
    .noise_restart(rs[1]), .noise_follow(fo[1]));
  psg_reg_port #(.VARIANT(VAR_STRICT)) dut_st (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .tick_en(tick_en),
    .ready(rdy[2]), .tone_period(tp[2]), .atten(at[2]), .noise_ctl(nc[2]),
    .noise_restart(rs[2]), .noise_follow(fo[2]));

  localparam int F_P0 = 0, F_P1 = 1, F_P2 = 2, F_A0 = 3, F_A1 = 4, F_A2 = 5, F_A3 = 6;
  localparam int F_CTL = 7, F_RS = 8, F_FO = 9, F_RDY = 10;

  typedef struct {
    int          due;
    int          d;
    int          f;
    logic [10:0] val;
    string       req;
  } exp_t;

  exp_t q[$];
  exp_t it_m;
  int   cyc = 0;
  int   last_due = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [10:0] act(int d, int f);
    if (f <= F_P2)  return tp[d][f*11 +: 11];
    if (f <= F_A3)  return 11'(at[d][(f-F_A0)*4 +: 4]);
    if (f == F_CTL) return 11'(nc[d]);
    if (f == F_RS)  return 11'(rs[d]);
    if (f == F_FO)  return 11'(fo[d]);
    return 11'(rdy[d]);
  endfunction

  task automatic check(int d, int f, logic [10:0] e, string req);
    logic [10:0] a;
    a = act(d, f);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s variant=%0d field=%0d actual=0x%0h expected=0x%0h", req, d, f, a, e);
    end
  endtask

  // monitor: pops expectations when their cycle arrives
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      it_m = q.pop_front();
      check(it_m.d, it_m.f, it_m.val, it_m.req);
    end
  end

  task automatic step(logic en, logic [7:0] b, logic t);
    @(negedge clk);
    wr_en = en; wr_data = b; tick_en = t;
    last_due = cyc + 1;
  endtask

  task automatic wr(logic [7:0] b);
    step(1'b1, b, 1'b0);
  endtask

  task automatic idle();
    step(1'b0, 8'h00, 1'b0);
  endtask

  task automatic ex(int d, int f, logic [10:0] v, string req);
    exp_t e;
    e.due = last_due; e.d = d; e.f = f; e.val = v; e.req = req;
    q.push_back(e);
  endtask

  task automatic ex3(int f, logic [10:0] v0, logic [10:0] v1, logic [10:0] v2, string req);
    ex(0, f, v0, req); ex(1, f, v1, req); ex(2, f, v2, req);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; tick_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5 reset state, R4 zero substitution
    check(0, F_P0, 11'h400, "R5"); check(1, F_P0, 11'h000, "R5"); check(2, F_P0, 11'h400, "R5");
    for (int f = F_A0; f <= F_CTL; f++) for (int d = 0; d < 3; d++) check(d, f, 0, "R5");
    for (int d = 0; d < 3; d++) check(d, F_RDY, 1, "R5");

    wr(8'h05);                              // data byte hits reset pointer
    ex3(F_P0, 11'h050, 11'h000, 11'h050, "R5");
    ex3(F_A1, 0, 5, 0, "R5");
    ex3(F_RDY, 0, 0, 0, "R8");
    wr(8'h8A);                              // latch reg 0
    ex3(F_P0, 11'h05A, 11'h00A, 11'h05A, "R1");
    wr(8'h3F);                              // data upper bits
    ex3(F_P0, 11'h3FA, 11'h3FA, 11'h3FA, "R2");
    wr(8'hA5);                              // latch reg 2
    ex3(F_P1, 11'h005, 11'h005, 11'h005, "R1");
    wr(8'h3F);
    ex3(F_P1, 11'h3F5, 11'h3F5, 11'h3F5, "R2");
    wr(8'hB7);                              // latch att ch1
    ex3(F_A1, 7, 7, 7, "R3");
    wr(8'h02);                              // data to att ch1
    ex3(F_A1, 2, 2, 7, "R7");
    ex(2, F_RDY, 0, "R8");
    wr(8'hE4);                              // noise ctl, mode 1
    ex3(F_CTL, 4, 4, 4, "R6");
    ex3(F_RS, 1, 1, 1, "R6");
    wr(8'hE5);                              // mode unchanged
    ex3(F_RS, 1, 1, 0, "R6");
    ex3(F_CTL, 5, 5, 5, "R6");
    wr(8'h06);                              // data byte to noise ctl
    ex3(F_CTL, 6, 6, 5, "R7");
    ex3(F_RS, 1, 1, 0, "R7");
    wr(8'hE7);                              // rate 3
    ex3(F_CTL, 7, 7, 7, "R6");
    ex3(F_RS, 1, 1, 0, "R6");
    wr(8'hC0);                              // ch2 period latch, zero value
    ex3(F_FO, 1, 1, 1, "R9");
    ex3(F_P2, 11'h400, 11'h000, 11'h400, "R4");
    wr(8'h01);
    ex3(F_P2, 11'h010, 11'h010, 11'h010, "R2");
    ex3(F_FO, 1, 1, 1, "R9");
    wr(8'hE0);                              // mode back to 0, rate 0
    ex3(F_RS, 1, 1, 1, "R6");
    wr(8'hC3);
    ex3(F_FO, 0, 0, 0, "R9");
    ex3(F_P2, 11'h013, 11'h013, 11'h013, "R1");
    idle();
    ex3(F_RS, 0, 0, 0, "R10");
    ex3(F_FO, 0, 0, 0, "R10");
    ex3(F_RDY, 0, 0, 0, "R8");
    step(1'b0, 8'h00, 1'b1);                // tick
    ex3(F_RDY, 1, 1, 1, "R8");
    wr(8'hFF);                              // att ch3
    ex3(F_A3, 15, 15, 15, "R3");
    idle();
    wr(8'hDC);                              // re-arm while low
    ex3(F_A2, 12, 12, 12, "R3");
    ex3(F_RDY, 0, 0, 0, "R8");
    step(1'b0, 8'h00, 1'b1);
    ex3(F_RDY, 1, 1, 1, "R8");
    step(1'b1, 8'h9C, 1'b1);                // write with tick in same cycle
    ex3(F_A0, 12, 12, 12, "R3");
    ex3(F_RDY, 0, 0, 0, "R8");
    step(1'b0, 8'h00, 1'b1);
    ex3(F_RDY, 1, 1, 1, "R8");
    repeat (4) idle();
    if (q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R10 unchecked expectations actual=%0d expected=0", q.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule